// File: doc/BRIEF.md
# Down-Counting Capture Timer

This peripheral holds a 16-bit counter that steps down by one on every cycle in which the instruction-clock enable is high. It counts freely for as long as capture mode is selected. An external capture pin is resynchronised and watched for one chosen edge polarity. When that edge arrives, the counter value of that moment is copied into a 16-bit capture register and a capture pending flag is raised. When the counter steps past zero it wraps to all ones and raises an underflow pending flag.

Software reaches the block through a byte-wide register port. It has two counter bytes, two capture bytes and one control byte. The control byte holds the mode, the edge polarity, the interrupt enable and both pending flags. The edge polarity can be flipped while the counter runs, so software can capture a rising edge and then a falling edge and measure a pulse width. A single level interrupt request is raised while the local enable and the external global enable are both set and either flag is pending.

Top module: `capture_timer`

## Requirements
- R1: After reset every register (counter bytes, capture bytes, control byte) reads 0x00 and `irq` is low.
- R2: While the control mode field (bits 7:6) equals 2'b01, the counter drops by one in each cycle with `tick` high and does not move when `tick` is low. A step from 0x0000 gives 0xFFFF.
- R3: A step from 0x0000 in capture mode sets the underflow flag, which is control bit 0.
- R4: With control bit 1 = 1 a rising edge, and with bit 1 = 0 a falling edge, of the two-stage-synchronised `cap_pin` copies the counter into the capture register and sets the capture flag (control bit 5). The counter bytes sit at addresses 0 (low) and 1 (high), the capture bytes at 2 (low) and 3 (high), and the control byte at 4.
- R5: An edge of the polarity not selected, or no edge at all, leaves the capture register and the capture flag unchanged.
- R6: Writing a new bit 1 while the mode stays 2'b01 changes the polarity used for following edges, and the counter keeps running.
- R7: A capture and an underflow in the same cycle set both flags. The captured value is the count before that step.
- R8: In capture mode a control write of 0 to bit 0 or bit 5 clears that flag, and a write of 1 never sets it. A flag event in the same cycle as a clearing write wins.
- R9: `irq` is high exactly when control bit 4, `gie` and at least one pending flag are all set.
- R10: The counter bytes take bus writes only while the counter is stopped. Writes made while it runs are ignored.
- R11: The counter runs when the mode is 2'b01 or control bit 0 is set. Leaving capture mode while clearing bit 0 stops it. Outside capture mode bit 0 is an ordinary read/write start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-clock enable; one count step per high cycle |
| cap_pin | input | 1 | Asynchronous capture input |
| gie | input | 1 | Global interrupt enable from the core |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The step properties assume that `tick` is a clean one-cycle-per-step enable, and that the capture pin holds each level for longer than the synchroniser depth. The stimulus changes `cap_pin` only at falling clock edges and holds every level for at least four cycles. The stepping and hold checks also rely on no counter-byte write reaching a running counter. Most capture tests therefore keep `tick` low so that the captured value is known exactly. The one coincident capture and underflow case raises `tick` for the single cycle in which the synchronised edge is seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'b00,
        MODE_CAPTURE = 2'b01,
        MODE_ALT_A   = 2'b10,
        MODE_ALT_B   = 2'b11
    } tmr_mode_e;

    // Control byte, MSB first: mode[7:6], cap_pend[5], irq_en[4], spare[3:2],
    // rise_sel[1], uf_start[0]
    typedef struct packed {
        tmr_mode_e  mode;
        logic       cap_pend;
        logic       irq_en;
        logic [1:0] spare;
        logic       rise_sel;
        logic       uf_start;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     sampled;

    assign sampled = st_q.sync[STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = (st_q.sync << 1) | STAGES'(pin);
        st_d.prev = sampled;
        edge_hit  = rise_sel ? (sampled & ~st_q.prev) : (~sampled & st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  logic [W/8-1:0] wr_byte,
    input  logic [7:0]     wdata,
    output logic [W-1:0]   count,
    output logic           uflow
);
    localparam int NB = W / 8;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < NB; i++) begin
            if (wr_byte[i]) cnt_d[i*8 +: 8] = wdata;
        end
        if (run && tick) cnt_d = cnt_q - 1'b1;
        uflow = run && tick && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cap_pin,
    input  logic              gie,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int NBYTES    = CNT_W / 8;
    localparam int CAP_BASE  = NBYTES;
    localparam int CTRL_ADDR = 2 * NBYTES;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        tmr_ctrl_t        ctrl;
    } top_st_t;

    top_st_t          st_d, st_q;
    tmr_ctrl_t        wr_ctrl;
    logic             run, ctrl_wr, cap_evt, edge_hit, uflow;
    logic [NBYTES-1:0] cnt_wr;
    logic [CNT_W-1:0] count;

    // Signals observed by the bound checker
    logic             mode_cap_q, uf_q, capf_q, cnt_wr_any;
    logic [CNT_W-1:0] cap_q;

    assign run     = (st_q.ctrl.mode == MODE_CAPTURE) || st_q.ctrl.uf_start;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign wr_ctrl = tmr_ctrl_t'(bus_wdata);
    assign cap_evt = edge_hit && (st_q.ctrl.mode == MODE_CAPTURE);

    for (genvar b = 0; b < NBYTES; b++) begin : g_cnt_wr
        assign cnt_wr[b] = bus_wr && !run && (bus_addr == ADDR_W'(b));
    end

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .rise_sel (st_q.ctrl.rise_sel),
        .edge_hit (edge_hit)
    );

    tmr_downcounter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .wr_byte (cnt_wr),
        .wdata   (bus_wdata),
        .count   (count),
        .uflow   (uflow)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.mode     = wr_ctrl.mode;
            st_d.ctrl.irq_en   = wr_ctrl.irq_en;
            st_d.ctrl.rise_sel = wr_ctrl.rise_sel;
            st_d.ctrl.spare    = '0;
            st_d.ctrl.cap_pend = st_q.ctrl.cap_pend & wr_ctrl.cap_pend;
            if (st_q.ctrl.mode == MODE_CAPTURE)
                st_d.ctrl.uf_start = st_q.ctrl.uf_start & wr_ctrl.uf_start;
            else
                st_d.ctrl.uf_start = wr_ctrl.uf_start;
        end
        if (cap_evt) begin
            st_d.cap           = count;
            st_d.ctrl.cap_pend = 1'b1;
        end
        if (uflow && (st_q.ctrl.mode == MODE_CAPTURE))
            st_d.ctrl.uf_start = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (bus_addr == ADDR_W'(i))            bus_rdata = count[i*8 +: 8];
            if (bus_addr == ADDR_W'(CAP_BASE + i)) bus_rdata = st_q.cap[i*8 +: 8];
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = st_q.ctrl;
    end

    assign irq = st_q.ctrl.irq_en && gie && (st_q.ctrl.cap_pend || st_q.ctrl.uf_start);

    assign mode_cap_q = (st_q.ctrl.mode == MODE_CAPTURE);
    assign uf_q       = st_q.ctrl.uf_start;
    assign capf_q     = st_q.ctrl.cap_pend;
    assign cap_q      = st_q.cap;
    assign cnt_wr_any = |cnt_wr;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         gie,
    input logic         irq,
    input logic         mode_cap,
    input logic         uf,
    input logic         capf,
    input logic         cnt_wr,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cap
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cap && tick) |=> (cnt == ($past(cnt) - W'(1))));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cap && tick && cnt == '0) |=> (cnt == '1));

    assert_uf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cap && tick && cnt == '0) |=> uf);

    assert_cap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap) |-> capf);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && (uf || capf)));

endmodule

bind capture_timer tmr_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .gie      (gie),
    .irq      (irq),
    .mode_cap (mode_cap_q),
    .uf       (uf_q),
    .capf     (capf_q),
    .cnt_wr   (cnt_wr_any),
    .cnt      (count),
    .cap      (cap_q)
);

// File: tb/test_capture_timer.sv
module test_capture_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cap_pin = 1'b0;
    logic       gie = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    capture_timer i_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin), .gie(gie),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {count value, rising select, pin level before, pin level after}
    localparam logic [18:0] VEC [6] = '{
        {16'h1234, 1'b1, 1'b0, 1'b1},
        {16'hBEEF, 1'b1, 1'b1, 1'b0},
        {16'h00A5, 1'b0, 1'b1, 1'b0},
        {16'hFFFF, 1'b0, 1'b0, 1'b1},
        {16'h8001, 1'b1, 1'b0, 1'b0},
        {16'h7F00, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic [15:0] exp_cap;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(3'd4, b);  chk("R1 ctrl", {8'h0, b}, 16'h0000);
        rd16(3'd0, w); chk("R1 count", w, 16'h0000);
        rd16(3'd2, w); chk("R1 capture", w, 16'h0000);
        chk("R1 irq", {15'h0, irq}, 16'h0000);

        // R4 / R5 vector table, counter held still (tick low)
        exp_cap = 16'h0000;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] val;
            logic rise, l1, l2, hit;
            {val, rise, l1, l2} = VEC[k];
            hit = rise ? (!l1 && l2) : (l1 && !l2);
            wr(3'd4, 8'h00);
            cap_pin = l1;
            wr(3'd0, val[7:0]);
            wr(3'd1, val[15:8]);
            idle(4);
            wr(3'd4, 8'h50 | {6'b0, rise, 1'b0});
            @(negedge clk); cap_pin = l2;
            idle(5);
            if (hit) exp_cap = val;
            rd(3'd4, b);
            chk(hit ? "R4 capture flag" : "R5 no capture flag", {15'h0, b[5]}, {15'h0, hit});
            rd16(3'd2, w);
            chk(hit ? "R4 capture value" : "R5 capture unchanged", w, exp_cap);
        end

        // R6 polarity switched while running
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h42);
        wr(3'd1, 8'h00);
        cap_pin = 1'b0;
        idle(4);
        wr(3'd4, 8'h52);
        wr(3'd4, 8'h50);
        @(negedge clk); cap_pin = 1'b1;
        idle(5);
        rd(3'd4, b);  chk("R6 rising ignored after switch", {8'h0, b}, 16'h0050);
        @(negedge clk); cap_pin = 1'b0;
        idle(5);
        rd(3'd4, b);  chk("R6 falling captured", {8'h0, b}, 16'h0070);
        rd16(3'd2, w); chk("R6 capture value", w, 16'h0042);

        // R8 flag write semantics
        wr(3'd4, 8'h70);
        rd(3'd4, b);  chk("R8 write 1 keeps flag", {8'h0, b}, 16'h0070);
        wr(3'd4, 8'h50);
        rd(3'd4, b);  chk("R8 write 0 clears flag", {8'h0, b}, 16'h0050);
        wr(3'd4, 8'h71);
        rd(3'd4, b);  chk("R8 write 1 does not set", {8'h0, b}, 16'h0050);

        // R2 / R3 / R9 counting, wrap, underflow, interrupt
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h50);
        gie = 1'b1;
        ticks(3);
        rd16(3'd0, w); chk("R2 count after 3 steps", w, 16'h0000);
        rd(3'd4, b);  chk("R3 no flag before wrap", {8'h0, b}, 16'h0050);
        chk("R9 irq low without flag", {15'h0, irq}, 16'h0000);
        ticks(1);
        rd16(3'd0, w); chk("R2 wrap to all ones", w, 16'hFFFF);
        rd(3'd4, b);  chk("R3 underflow flag", {8'h0, b}, 16'h0051);
        chk("R9 irq high", {15'h0, irq}, 16'h0001);
        gie = 1'b0;
        idle(1);
        chk("R9 irq masked by gie", {15'h0, irq}, 16'h0000);
        gie = 1'b1;
        wr(3'd4, 8'h41);
        chk("R9 irq masked by enable", {15'h0, irq}, 16'h0000);
        wr(3'd4, 8'h50);
        chk("R8 irq drops after clear", {15'h0, irq}, 16'h0000);

        // R10 write ignored while running
        wr(3'd0, 8'h99);
        rd16(3'd0, w); chk("R10 write ignored while running", w, 16'hFFFF);

        // R11 stop and start bit outside capture mode
        wr(3'd4, 8'h00);
        ticks(2);
        rd16(3'd0, w); chk("R11 stopped", w, 16'hFFFF);
        wr(3'd4, 8'h01);
        ticks(2);
        rd16(3'd0, w); chk("R11 start bit runs", w, 16'hFFFD);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        rd16(3'd0, w); chk("R10 load while stopped", w, 16'h0000);

        // R7 capture and underflow in the same cycle
        cap_pin = 1'b0;
        idle(4);
        wr(3'd4, 8'h52);
        @(negedge clk); cap_pin = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        rd(3'd4, b);  chk("R7 both flags", {8'h0, b}, 16'h0073);
        rd16(3'd2, w); chk("R7 captured pre-step value", w, 16'h0000);
        rd16(3'd0, w); chk("R7 counter wrapped", w, 16'hFFFF);
        chk("R9 irq with both flags", {15'h0, irq}, 16'h0001);
        wr(3'd4, 8'h52);
        rd(3'd4, b);  chk("R8 both cleared", {8'h0, b}, 16'h0052);
        chk("R9 irq low after clear", {15'h0, irq}, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule